// File: doc/BRIEF.md
# Debug Capture and Stimulus Controller

This block is an on-chip logic-analyzer core. A host issues commands to it: load a stimulus word, arm, soft reset, or read back a stored sample. Once armed, the core compares the monitored bus with a host-supplied value under a host-supplied mask. On the first matching clock it starts recording. It then stores 1024 consecutive samples of the bus into an internal buffer, at addresses 0 to 1023.

The core also drives three signals back into the design under test. The first is an active-low reset that the design may use. The second is an arm flag. The third is a 36-bit stimulus word, which the design may use only while the arm flag is high, and which never changes during that time. A parameter inserts the same number of register stages in front of all three signals. This allows timing closure at high clock rates, at the cost of equal added latency.

Commands enter on a valid/ready channel. Read results return on a second valid/ready channel. While a read result waits to be taken, no new command is accepted. The result is held steady until `rsp_ready` takes it, so a slow host applies back-pressure simply by leaving `rsp_ready` low.

Top module: `dbg_capture_core`

## Requirements
- R1: After a trigger, the sample present in the trigger cycle is stored at address 0. The sample of each following cycle is stored at the next address, up to address 1023. A read of address `a` then returns the sample of trigger cycle + `a`.
- R2: `MON_W` sets the monitored width. The only legal values are 36, 72, 108 and 144, and the default is 144.
- R3: Arming latches `trig_value` and `trig_mask`. The trigger fires in the first armed cycle where `(mon_data ^ value) & mask` is zero. A zero mask therefore fires in the first cycle after the arm command is accepted.
- R4: `cap_state` reads 0 when idle, 1 when armed and waiting, 2 when capturing and 3 when done. The state becomes 3 in the cycle after the sample for address 1023 is written, and stays there.
- R5: `arm_out` goes high after an accepted arm command and stays high through capturing and done. `arm_out` is low whenever `rstn_out` is low.
- R6: `stim_out` never changes while `arm_out` stays high. A stimulus write accepted while armed (state not 0) has no effect.
- R7: `rstn_out` is active low. It is held low for exactly 4 cycles after a soft-reset command, and for 4 cycles after `rst_n` is released. A soft reset returns the state to idle and clears the write pointer, so the next capture starts at address 0 again.
- R8: `PIPE_STAGES` adds the same number of clock cycles of latency to `rstn_out`, `arm_out` and `stim_out`.
- R9: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. The `cmd_op` codes are 0 for stimulus write, 1 for arm, 2 for soft reset and 3 for read. `cmd_ready` is low while a read result is pending and while the reset hold is active.
- R10: A read result appears as `rsp_valid` one cycle after the read is accepted. `rsp_valid`, `rsp_data` and `rsp_err` hold steady until a cycle with `rsp_ready` high.
- R11: A read accepted while capturing returns `rsp_data` = 0 with `rsp_err` = 1. A read in any other state returns `rsp_err` = 0.
- R12: An arm command is acted on only in the idle or done state. Arming from the done state starts a new capture. An arm command while waiting or capturing has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_data | input | MON_W | Monitored bus |
| trig_value | input | MON_W | Trigger compare value, latched on arm |
| trig_mask | input | MON_W | Trigger compare mask, latched on arm |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Command ready |
| cmd_op | input | 2 | Command code (0 stim, 1 arm, 2 soft reset, 3 read) |
| cmd_addr | input | AW | Sample address for a read |
| cmd_wdata | input | 36 | Stimulus word for a write |
| rsp_valid | output | 1 | Read result valid |
| rsp_ready | input | 1 | Read result taken |
| rsp_data | output | MON_W | Read sample |
| rsp_err | output | 1 | Read was refused during capture |
| cap_state | output | 2 | Capture state |
| rstn_out | output | 1 | Active-low reset toward the design under test |
| arm_out | output | 1 | Armed flag toward the design under test |
| stim_out | output | 36 | Stimulus word toward the design under test |

## Verification
The assertions assume three things about the inputs. The host presents only one command per cycle. It issues no command while `cmd_ready` is low. It holds `rsp_ready` independently of the result contents. The stimulus drives commands only after checking `cmd_ready` at a falling edge, and toggles `rsp_ready` randomly so that held results are exercised. It moves the monitor bus to a new, distinct pattern every cycle, so each stored address identifies exactly one capture cycle and the trigger can only match where the bench intends.

// File: rtl/dbg_cap_pkg.sv
package dbg_cap_pkg;
  localparam int STIM_W   = 36;
  localparam int RST_HOLD = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_CAPT = 2'd2,
    ST_DONE = 2'd3
  } cap_state_e;

  typedef enum logic [1:0] {
    OP_STIM = 2'd0,
    OP_ARM  = 2'd1,
    OP_SRST = 2'd2,
    OP_READ = 2'd3
  } cap_op_e;
endpackage

// File: rtl/dbg_cap_ctrl.sv
module dbg_cap_ctrl
  import dbg_cap_pkg::*;
#(
  parameter int MON_W = 144,
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_req,
  input  logic             srst_req,
  input  logic [MON_W-1:0] mon_data,
  input  logic [MON_W-1:0] trig_value,
  input  logic [MON_W-1:0] trig_mask,
  output cap_state_e       state,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [MON_W-1:0] wr_data,
  output logic             rstn_int
);
  localparam int          HCW  = $clog2(RST_HOLD + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  cap_state_e       state_q;
  logic [AW-1:0]    wptr_q;
  logic [HCW-1:0]   hold_q;
  logic [MON_W-1:0] tval_q;
  logic [MON_W-1:0] tmsk_q;
  logic             hit;

  // masked compare of the live bus against the latched trigger
  assign hit = ((mon_data ^ tval_q) & tmsk_q) == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wptr_q  <= '0;
      hold_q  <= HCW'(RST_HOLD);
      tval_q  <= '0;
      tmsk_q  <= '0;
    end else if (srst_req) begin
      state_q <= ST_IDLE;
      wptr_q  <= '0;
      hold_q  <= HCW'(RST_HOLD);
    end else begin
      if (hold_q != '0) hold_q <= hold_q - 1'b1;
      unique case (state_q)
        ST_IDLE, ST_DONE: begin
          if (arm_req) begin
            tval_q  <= trig_value;
            tmsk_q  <= trig_mask;
            wptr_q  <= '0;
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (hit) begin
            wptr_q  <= AW'(1);
            state_q <= ST_CAPT;
          end
        end
        ST_CAPT: begin
          if (wptr_q == LAST) state_q <= ST_DONE;
          else                wptr_q  <= wptr_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state    = state_q;
  assign rstn_int = (hold_q == '0);
  assign wr_en    = ((state_q == ST_WAIT) && hit) || (state_q == ST_CAPT);
  assign wr_addr  = (state_q == ST_WAIT) ? '0 : wptr_q;
  assign wr_data  = mon_data;

  // R4: the write of the final address moves the core to done
  a_r4_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CAPT && wr_addr == LAST && !srst_req) |=> state_q == ST_DONE);

  // R3: a zero mask fires in the first armed cycle, writing address 0
  a_r3_zero_mask_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_req && !srst_req && (state_q == ST_IDLE || state_q == ST_DONE) && trig_mask == '0)
      |=> (wr_en && wr_addr == '0));

  // R7: reset output stays low for at least the hold length before rising
  a_r7_hold_length: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rstn_int) |-> (!$past(rstn_int, 1) && !$past(rstn_int, 2) &&
                         !$past(rstn_int, 3) && !$past(rstn_int, 4)));

  // R7: soft reset returns to idle with the pointer cleared
  a_r7_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
    srst_req |=> (state_q == ST_IDLE && wptr_q == '0 && !rstn_int));

  // R12: arm while waiting or capturing leaves the state alone
  a_r12_arm_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_req && !srst_req && state_q == ST_CAPT && wptr_q != LAST) |=> state_q == ST_CAPT);
endmodule

// File: rtl/dbg_cap_buffer.sv
module dbg_cap_buffer #(
  parameter int W     = 144,
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data      <= mem[rd_addr];
  end
endmodule

// File: rtl/dbg_cap_host.sv
module dbg_cap_host
  import dbg_cap_pkg::*;
#(
  parameter int MON_W = 144,
  parameter int AW    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [AW-1:0]     cmd_addr,
  input  logic [STIM_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [MON_W-1:0]  rsp_data,
  output logic              rsp_err,
  input  cap_state_e        state,
  input  logic              rstn_int,
  output logic              arm_req,
  output logic              srst_req,
  output logic              rd_en,
  output logic [AW-1:0]     rd_addr,
  input  logic [MON_W-1:0]  rd_data,
  output logic [STIM_W-1:0] stim_q
);
  logic take;
  logic armed;
  logic vld_q;
  logic err_q;

  assign armed     = (state != ST_IDLE);
  assign cmd_ready = !vld_q && rstn_int;
  assign take      = cmd_valid && cmd_ready;
  assign arm_req   = take && (cmd_op == OP_ARM);
  assign srst_req  = take && (cmd_op == OP_SRST);
  assign rd_en     = take && (cmd_op == OP_READ) && (state != ST_CAPT);
  assign rd_addr   = cmd_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
      stim_q <= '0;
    end else begin
      if (take && cmd_op == OP_STIM && !armed) stim_q <= cmd_wdata;
      if (take && cmd_op == OP_READ) begin
        vld_q <= 1'b1;
        err_q <= (state == ST_CAPT);
      end else if (vld_q && rsp_ready) begin
        vld_q <= 1'b0;
      end
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_err   = err_q;
  assign rsp_data  = err_q ? '0 : rd_data;

  // R10: a pending result is held until taken
  a_r10_rsp_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_err)));

  // R11: read during capture answers with zero data and the error flag
  a_r11_blocked_read: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd_op == OP_READ && state == ST_CAPT) |=> (rsp_valid && rsp_err && rsp_data == '0));

  // R6: a stimulus write while armed leaves the word untouched
  a_r6_stim_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd_op == OP_STIM && armed) |=> $stable(stim_q));
endmodule

// File: rtl/dbg_capture_core.sv
module dbg_capture_core
  import dbg_cap_pkg::*;
#(
  parameter int MON_W       = 144,
  parameter int DEPTH       = 1024,
  parameter int PIPE_STAGES = 0,
  parameter int AW          = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MON_W-1:0]  mon_data,
  input  logic [MON_W-1:0]  trig_value,
  input  logic [MON_W-1:0]  trig_mask,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [AW-1:0]     cmd_addr,
  input  logic [STIM_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [MON_W-1:0]  rsp_data,
  output logic              rsp_err,
  output logic [1:0]        cap_state,
  output logic              rstn_out,
  output logic              arm_out,
  output logic [STIM_W-1:0] stim_out
);
  localparam int PW = STIM_W + 2;

  initial begin
    a_r2_width_legal: assert (MON_W == 36 || MON_W == 72 || MON_W == 108 || MON_W == 144)
      else $error("MON_W must be 36, 72, 108 or 144");
  end

  cap_state_e        state;
  logic              wr_en;
  logic [AW-1:0]     wr_addr;
  logic [MON_W-1:0]  wr_data;
  logic              rstn_int;
  logic              arm_req;
  logic              srst_req;
  logic              rd_en;
  logic [AW-1:0]     rd_addr;
  logic [MON_W-1:0]  rd_data;
  logic [STIM_W-1:0] stim_q;
  logic [PW-1:0]     dut_side;

  dbg_cap_ctrl #(.MON_W(MON_W), .DEPTH(DEPTH), .AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .arm_req(arm_req), .srst_req(srst_req),
    .mon_data(mon_data), .trig_value(trig_value), .trig_mask(trig_mask),
    .state(state), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rstn_int(rstn_int)
  );

  dbg_cap_buffer #(.W(MON_W), .DEPTH(DEPTH), .AW(AW)) u_buf (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  dbg_cap_host #(.MON_W(MON_W), .AW(AW)) u_host (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_err(rsp_err), .state(state), .rstn_int(rstn_int),
    .arm_req(arm_req), .srst_req(srst_req), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .stim_q(stim_q)
  );

  assign cap_state = state;

  // reset, arm flag and stimulus travel as one word so their delays match
  assign dut_side = {rstn_int, (state != ST_IDLE), stim_q};

  generate
    if (PIPE_STAGES == 0) begin : g_direct
      assign {rstn_out, arm_out, stim_out} = dut_side;
    end else begin : g_piped
      logic [PW-1:0] stage_q [PIPE_STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < PIPE_STAGES; i++) stage_q[i] <= '0;
        end else begin
          stage_q[0] <= dut_side;
          for (int i = 1; i < PIPE_STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
      end
      assign {rstn_out, arm_out, stim_out} = stage_q[PIPE_STAGES-1];
    end
  endgenerate

  // R5: the arm flag is never high while the reset output is active
  a_r5_arm_low_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !rstn_out |-> !arm_out);

  // R6: stimulus frozen while armed
  a_r6_stim_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_out && $past(arm_out)) |-> $stable(stim_out));
endmodule

// File: tb/dbg_capture_core_tb.sv
module dbg_capture_core_tb;
  import dbg_cap_pkg::*;

  localparam int MW = 144, DEPTH = 1024, AW = 10, SW = 36, PIPE = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [MW-1:0] mon, trig_value, trig_mask;
  logic          cmd_valid = 1'b0, cmd_ready;
  logic [1:0]    cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [SW-1:0] cmd_wdata = '0;
  logic          rsp_valid, rsp_ready = 1'b0, rsp_err;
  logic [MW-1:0] rsp_data;
  logic [1:0]    cap_state;
  logic          rstn_out, arm_out;
  logic [SW-1:0] stim_out;

  int unsigned k = 0;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  dbg_capture_core #(.MON_W(MW), .DEPTH(DEPTH), .PIPE_STAGES(PIPE), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .mon_data(mon), .trig_value(trig_value), .trig_mask(trig_mask),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_err(rsp_err), .cap_state(cap_state), .rstn_out(rstn_out), .arm_out(arm_out),
    .stim_out(stim_out)
  );

  // distinct bus value for every cycle index; low 16 bits unique below 65536
  function automatic logic [MW-1:0] pat(int unsigned n);
    return {32'(n * 32'h9E3779B1), 32'(n * 32'h85EBCA6B) ^ 32'h5A5A5A5A,
            32'(n * 32'hC2B2AE35), 32'(~n * 32'h27D4EB2F), 16'(n ^ (n >> 5))};
  endfunction

  initial begin
    mon = pat(0);
    forever begin
      @(negedge clk);
      k = k + 1;
      mon = pat(k);
    end
  end

  task automatic chk(input bit ok, input string req, input logic [MW-1:0] act, input logic [MW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic step_to(input int unsigned t);
    while (k < t) step();
  endtask

  task automatic send(input logic [1:0] op, input logic [AW-1:0] a, input logic [SW-1:0] d,
                      output int unsigned n);
    while (!cmd_ready) step();
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
    n = k;
    step();
    cmd_valid = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [MW-1:0] data, output logic err);
    int unsigned n;
    bit r, v, stable_ok;
    logic [MW-1:0] first;
    send(OP_READ, a, '0, n);
    first = rsp_data;
    stable_ok = rsp_valid;
    do begin
      r = 1'($urandom_range(0, 1));
      rsp_ready = r;
      v = rsp_valid;
      data = rsp_data;
      err = rsp_err;
      if (!v || data !== first) stable_ok = 1'b0;
      step();
    end while (!(v && r));
    rsp_ready = 1'b0;
    chk(stable_ok, "R10 result held until taken", data, first);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R1 watchdog expired", '0, 1);
    finish_run();
  end

  initial begin
    int unsigned n, base, t, ns, first_low, lows;
    logic [MW-1:0] d;
    logic e;
    logic [SW-1:0] s1, s2, s3;
    bit arm_bad;

    void'($urandom(32'd7321));
    trig_value = '0;
    trig_mask  = '0;

    // reset state
    repeat (3) step();
    chk(rstn_out == 1'b0, "R7 reset output low in reset", MW'(rstn_out), 0);
    chk(arm_out == 1'b0, "R5 arm low in reset", MW'(arm_out), 0);
    chk(cap_state == 2'd0, "R4 idle after reset", MW'(cap_state), 0);
    chk(cmd_ready == 1'b0, "R9 no commands during reset", MW'(cmd_ready), 0);
    rst_n = 1'b1;
    n = k;
    step_to(n + 3 + PIPE);
    chk(rstn_out == 1'b0, "R7 hold after reset release", MW'(rstn_out), 0);
    step();
    chk(rstn_out == 1'b1, "R7 reset output releases after hold", MW'(rstn_out), 1);

    // stimulus write while idle, latency check
    s1 = SW'({$urandom(), $urandom()});
    send(OP_STIM, '0, s1, n);
    step_to(n + PIPE);
    chk(stim_out == '0, "R8 stimulus not early", MW'(stim_out), 0);
    step();
    chk(stim_out == s1, "R8 stimulus after pipeline delay", MW'(stim_out), MW'(s1));

    // capture A: zero mask triggers at once
    trig_mask = '0;
    send(OP_ARM, '0, '0, n);
    base = n + 1;
    chk(cap_state == 2'd1, "R4 waiting right after arm", MW'(cap_state), 1);
    step();
    chk(cap_state == 2'd2, "R3 zero mask fires immediately", MW'(cap_state), 2);
    step_to(n + PIPE);
    chk(arm_out == 1'b0, "R8 arm flag not early", MW'(arm_out), 0);
    step();
    chk(arm_out == 1'b1, "R5 arm flag after delay", MW'(arm_out), 1);

    s2 = ~s1;
    send(OP_STIM, '0, s2, n);
    step_to(n + 2 + PIPE);
    chk(stim_out == s1, "R6 stimulus write ignored while armed", MW'(stim_out), MW'(s1));

    do_read(AW'(5), d, e);
    chk(e == 1'b1 && d == '0, "R11 read during capture refused", {d[MW-2:0], e}, 1);

    step_to(base + 1023);
    chk(cap_state == 2'd2, "R4 still capturing before last sample", MW'(cap_state), 2);
    step();
    chk(cap_state == 2'd3, "R4 done after last sample", MW'(cap_state), 3);
    chk(arm_out == 1'b1, "R5 arm stays high when done", MW'(arm_out), 1);

    do_read('0, d, e);
    chk(d == pat(base) && !e, "R1 address 0 holds trigger sample", d, pat(base));
    do_read(AW'(1023), d, e);
    chk(d == pat(base + 1023) && !e, "R1 last address", d, pat(base + 1023));
    for (int i = 0; i < 8; i++) begin
      int unsigned a;
      a = $urandom_range(1, 1022);
      do_read(AW'(a), d, e);
      chk(d == pat(base + a) && !e, "R1 random address", d, pat(base + a));
    end

    // capture B: re-arm from done with a value trigger on the low 16 bits
    t = k + 40 + $urandom_range(0, 100);
    trig_mask  = MW'(16'hFFFF);
    trig_value = pat(t) ^ {{4{$urandom()}}, 16'h0};
    send(OP_ARM, '0, '0, n);
    step_to(t);
    chk(cap_state == 2'd1, "R3 waits until masked match", MW'(cap_state), 1);
    step();
    chk(cap_state == 2'd2, "R12 rearm from done captures again", MW'(cap_state), 2);
    send(OP_ARM, '0, '0, n);
    step();
    chk(cap_state == 2'd2, "R12 arm during capture ignored", MW'(cap_state), 2);
    step_to(t + 1024);
    chk(cap_state == 2'd3, "R4 done after second capture", MW'(cap_state), 3);
    for (int i = 0; i < 4; i++) begin
      int unsigned a;
      a = (i == 0) ? 0 : $urandom_range(0, 1023);
      do_read(AW'(a), d, e);
      chk(d == pat(t + a), "R1 value-trigger capture contents", d, pat(t + a));
    end

    // capture C: soft reset in the middle of a capture
    trig_mask = '0;
    send(OP_ARM, '0, '0, n);
    step_to(n + 100);
    send(OP_SRST, '0, '0, ns);
    chk(cap_state == 2'd0, "R7 soft reset returns to idle", MW'(cap_state), 0);
    chk(cmd_ready == 1'b0, "R9 commands blocked during hold", MW'(cmd_ready), 0);
    lows = 0; first_low = 0; arm_bad = 1'b0;
    while (k < ns + 14) begin
      if (!rstn_out) begin
        if (lows == 0) first_low = k;
        lows++;
        if (arm_out) arm_bad = 1'b1;
      end
      step();
    end
    chk(lows == 4, "R7 reset output low for exactly 4 cycles", MW'(lows), 4);
    chk(first_low == ns + 1 + PIPE, "R8 reset output delay", MW'(first_low), MW'(ns + 1 + PIPE));
    chk(!arm_bad, "R5 arm low while reset output active", MW'(arm_bad), 0);

    s3 = SW'({$urandom(), $urandom()});
    send(OP_STIM, '0, s3, n);
    step_to(n + 1 + PIPE);
    chk(stim_out == s3, "R6 stimulus write accepted once disarmed", MW'(stim_out), MW'(s3));

    send(OP_ARM, '0, '0, n);
    base = n + 1;
    step_to(base + 1024);
    chk(cap_state == 2'd3, "R4 done after post-reset capture", MW'(cap_state), 3);
    do_read('0, d, e);
    chk(d == pat(base), "R7 pointer cleared by soft reset", d, pat(base));
    do_read(AW'(1023), d, e);
    chk(d == pat(base + 1023), "R7 post-reset capture last address", d, pat(base + 1023));

    finish_run();
  end
endmodule